// File: doc/BRIEF.md
# UART Hardware Flow Controller

This block decides, cycle by cycle, whether a FIFO-mode UART may accept more receive data and whether its transmitter may start the next character. On the receive side it drives the active-low request-to-send pin. The decision comes from the receive FIFO fill count, the programmed trigger level, the host's FIFO read strobe and a pulse from the deserializer that marks the first data bit of an incoming character. On the transmit side it passes the active-low clear-to-send pin through a synchronizer. It then samples that pin at a fixed 16x tick inside the last stop bit, and from this it drives a go/hold signal to the transmitter sequencer. It also suppresses the CTS-change interrupt request while automatic CTS handling is on.

Two configuration bits control the block. `cfg_afe` turns on automatic flow control. `cfg_rts` is the software RTS bit. With both bits set, RTS is automatic. With `cfg_afe` set and `cfg_rts` clear, only the CTS half works and RTS stays inactive. With `cfg_afe` clear, RTS follows the software bit and CTS is ignored.

The receive state machine `rx_st_t` has four states:
- RX_OPEN: RTS is active.
- RX_DRAIN: held until the FIFO is empty.
- RX_ARM: the 16th character is arriving.
- RX_FULL: the FIFO is full.

Its transitions are:
- OPEN to DRAIN: at a low trigger level.
- OPEN to ARM: at the first data bit while 15 bytes are held.
- OPEN to FULL, and ARM to FULL: when the count reaches 16.
- DRAIN to OPEN: when the FIFO is emptied.
- ARM to OPEN: when a read leaves at least two bytes free.
- FULL to OPEN: when one byte is free.

The transmit state machine `tx_st_t` has two states, TX_GO and TX_HOLD. Its transitions are:
- GO to HOLD: on idle with CTS inactive, or at the stop-bit midpoint with CTS inactive.
- HOLD to GO: when CTS is active.

Top module: `uart_autoflow_ctrl`

## Requirements
- R1: While `rst_n` is low, `rts_n` is 1 and `tx_go` is 0.
- R2: With `cfg_afe`=0, `rts_n` equals the inverse of `cfg_rts` from the cycle after a change, whatever the FIFO count. `tx_go` is 1 whatever `cts_n` is.
- R3: `trig_sel` selects the trigger level: 0 means 1 byte, 1 means 4, 2 means 8 and 3 means 14. With automatic RTS on and `trig_sel` 0 to 2, `rts_n` goes to 1 in the cycle after `rx_count` is at or above the level.
- R4: At levels 1, 4 and 8, `rts_n` stays 1 until the FIFO is emptied, either by `rx_count`=0 or by `rx_rd` while `rx_count`=1. It returns to 0 in the following cycle.
- R5: At level 14, a count of 14 or 15 alone leaves `rts_n` at 0. `rts_n` goes to 1 in the cycle after `rx_first_bit` while `rx_count`=15, or after `rx_count` reaches 16. A first-bit pulse at a lower count has no effect.
- R6: At level 14, `rts_n` returns to 0 in the cycle after the count falls below 16 from full. During the 16th character it returns to 0 when the count falls below 15.
- R7: With `cfg_afe`=1 and `cfg_rts`=0, `rts_n` stays 1 and the CTS gating still works.
- R8: With `cfg_afe`=1 and `tx_busy`=0, `tx_go` follows the active-low `cts_n` three cycles after a change: two synchronizer stages, then the state register.
- R9: While `tx_busy`=1, CTS is acted on only at the 8th `tx_tick16` of the last stop bit. If CTS is inactive there, `tx_go` is 0 from the next cycle. CTS going inactive at any other point of the character leaves `tx_go` at 1.
- R10: In hold, `tx_go` returns to 1 three cycles after `cts_n` goes low.
- R11: `cts_chg_irq` equals `cts_chg_req` when `cfg_afe`=0 and is 0 when `cfg_afe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_afe | input | 1 | Automatic flow control enable |
| cfg_rts | input | 1 | Software RTS bit |
| trig_sel | input | 2 | Receive trigger level code |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_rd | input | 1 | Host read of the receive FIFO |
| rx_first_bit | input | 1 | Pulse: first data bit of an incoming character received |
| tx_busy | input | 1 | Transmitter is sending a character |
| tx_last_stop | input | 1 | Transmitter is inside its last stop bit |
| tx_tick16 | input | 1 | 16x baud tick |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| cts_chg_req | input | 1 | Raw CTS-change interrupt request |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_go | output | 1 | Permission for the transmitter to start or continue |
| cts_chg_irq | output | 1 | Masked CTS-change interrupt request |

## Verification
A wrong receive state shows on `rts_n` in the cycle after the count, read or first-bit event that should have moved it. Examples are a hold released before the FIFO is empty, or a level-14 cutoff at the wrong count. A wrong transmit state or tick count shows on `tx_go`. It appears either at the cycle after the 8th stop-bit tick, or three cycles after a CTS change while idle. The sweeps walk each trigger level's fill and drain one count per cycle, so an error appears at the first count where the level rule is broken.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;

    typedef enum logic [1:0] {
        RX_OPEN  = 2'd0,
        RX_DRAIN = 2'd1,
        RX_ARM   = 2'd2,
        RX_FULL  = 2'd3
    } rx_st_t;

    typedef enum logic {
        TX_HOLD = 1'b0,
        TX_GO   = 1'b1
    } tx_st_t;

    // Trigger code to byte count, scaled to FIFO depth.
    function automatic int unsigned trig_level(input logic [1:0] code, input int unsigned depth);
        unique case (code)
            2'd0:    trig_level = 1;
            2'd1:    trig_level = depth / 4;
            2'd2:    trig_level = depth / 2;
            default: trig_level = depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic active
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-2:0], pin_n};
        end
    end

    assign active = ~pipe[STAGES-1];
endmodule

// File: rtl/rts_ctl.sv
module rts_ctl
    import uart_flow_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             sw_rts,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_rd,
    input  logic             rx_first_bit,
    output logic             rts_n
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DEPTH - 1);

    rx_st_t           st, st_nxt;
    logic             hi_mode;
    logic [CNT_W-1:0] lvl;

    assign hi_mode = (trig_sel == 2'd3);
    assign lvl     = CNT_W'(trig_level(trig_sel, DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= RX_OPEN;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            RX_OPEN: begin
                if (!hi_mode && rx_count >= lvl) begin
                    st_nxt = RX_DRAIN;
                end else if (hi_mode && rx_count >= FULL_CNT) begin
                    st_nxt = RX_FULL;
                end else if (hi_mode && rx_first_bit && rx_count == LAST_CNT) begin
                    st_nxt = RX_ARM;
                end
            end
            RX_DRAIN: begin
                if (rx_count == '0 || (rx_rd && rx_count == CNT_W'(1))) begin
                    st_nxt = RX_OPEN;
                end
            end
            RX_ARM: begin
                if (rx_count >= FULL_CNT) begin
                    st_nxt = RX_FULL;
                end else if (rx_count < LAST_CNT) begin
                    st_nxt = RX_OPEN;
                end
            end
            RX_FULL: begin
                if (rx_count < FULL_CNT) begin
                    st_nxt = RX_OPEN;
                end
            end
            default: st_nxt = RX_OPEN;
        endcase
        if (!auto_en) begin
            st_nxt = RX_OPEN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rts_n <= 1'b1;
        end else begin
            rts_n <= ~(sw_rts && (!auto_en || st_nxt == RX_OPEN));
        end
    end

    a_r2_sw_low: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rts |=> rts_n);
    a_r3_low_trig_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !hi_mode && st == RX_OPEN && rx_count >= lvl) |=> rts_n);
    a_r4_hold_until_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && st == RX_DRAIN && rx_count > CNT_W'(1)) |=> rts_n);
    a_r5_mid_char_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && hi_mode && st == RX_OPEN && rx_first_bit && rx_count == LAST_CNT) |=> rts_n);
    a_r6_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && st == RX_FULL && rx_count < FULL_CNT) |=> !rts_n);
endmodule

// File: rtl/tx_gate.sv
module tx_gate
    import uart_flow_pkg::*;
#(
    parameter int TICKS = 16,
    parameter int TCNT_W = $clog2(TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic afe,
    input  logic cts_act,
    input  logic tx_busy,
    input  logic tx_last_stop,
    input  logic tx_tick16,
    output logic tx_go
);
    localparam logic [TCNT_W-1:0] MID_IDX = TCNT_W'(TICKS / 2 - 1);

    tx_st_t            st, st_nxt;
    logic [TCNT_W-1:0] tcnt;
    logic              mid;

    // Ticks seen within the last stop bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (!tx_last_stop) begin
            tcnt <= '0;
        end else if (tx_tick16) begin
            tcnt <= tcnt + TCNT_W'(1);
        end
    end

    assign mid = tx_busy && tx_last_stop && tx_tick16 && (tcnt == MID_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= TX_HOLD;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            TX_GO: begin
                if (!cts_act && (!tx_busy || mid)) begin
                    st_nxt = TX_HOLD;
                end
            end
            TX_HOLD: begin
                if (cts_act) begin
                    st_nxt = TX_GO;
                end
            end
            default: st_nxt = TX_HOLD;
        endcase
        if (!afe) begin
            st_nxt = TX_GO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_go <= 1'b0;
        end else begin
            tx_go <= !afe || (st_nxt == TX_GO);
        end
    end

    a_r2_cts_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !afe |=> tx_go);
    a_r9_mid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (afe && st == TX_GO && mid && !cts_act) |=> !tx_go);
    a_r9_busy_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (afe && st == TX_GO && tx_busy && !mid) |=> tx_go);
    a_r10_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_HOLD && cts_act) |=> tx_go);
endmodule

// File: rtl/uart_autoflow_ctrl.sv
module uart_autoflow_ctrl #(
    parameter int DEPTH       = 16,
    parameter int CNT_W       = $clog2(DEPTH + 1),
    parameter int SYNC_STAGES = 2,
    parameter int TICKS       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_afe,
    input  logic             cfg_rts,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_rd,
    input  logic             rx_first_bit,
    input  logic             tx_busy,
    input  logic             tx_last_stop,
    input  logic             tx_tick16,
    input  logic             cts_n,
    input  logic             cts_chg_req,
    output logic             rts_n,
    output logic             tx_go,
    output logic             cts_chg_irq
);
    logic cts_act;
    logic auto_rts;

    assign auto_rts    = cfg_afe & cfg_rts;
    assign cts_chg_irq = cts_chg_req & ~cfg_afe;

    cts_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (cts_n),
        .active (cts_act)
    );

    rts_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) rts_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .auto_en      (auto_rts),
        .sw_rts       (cfg_rts),
        .trig_sel     (trig_sel),
        .rx_count     (rx_count),
        .rx_rd        (rx_rd),
        .rx_first_bit (rx_first_bit),
        .rts_n        (rts_n)
    );

    tx_gate #(.TICKS(TICKS)) txg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .afe          (cfg_afe),
        .cts_act      (cts_act),
        .tx_busy      (tx_busy),
        .tx_last_stop (tx_last_stop),
        .tx_tick16    (tx_tick16),
        .tx_go        (tx_go)
    );

    a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_afe |-> !cts_chg_irq);
endmodule

// File: tb/uart_autoflow_ctrl_tb.sv
`timescale 1ns/1ps
module uart_autoflow_ctrl_tb_top;
    localparam int DEPTH = 16;
    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_afe = 1'b0, cfg_rts = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic [CNT_W-1:0] rx_count = '0;
    logic rx_rd = 1'b0, rx_first_bit = 1'b0;
    logic tx_busy = 1'b0, tx_last_stop = 1'b0, tx_tick16 = 1'b0;
    logic cts_n = 1'b1, cts_chg_req = 1'b0;
    logic rts_n, tx_go, cts_chg_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    uart_autoflow_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_afe(cfg_afe), .cfg_rts(cfg_rts),
        .trig_sel(trig_sel), .rx_count(rx_count), .rx_rd(rx_rd),
        .rx_first_bit(rx_first_bit), .tx_busy(tx_busy),
        .tx_last_stop(tx_last_stop), .tx_tick16(tx_tick16), .cts_n(cts_n),
        .cts_chg_req(cts_chg_req), .rts_n(rts_n), .tx_go(tx_go),
        .cts_chg_irq(cts_chg_irq)
    );

    task automatic chk(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(rts_n, 1'b1, "R1 rts_n in reset");
        chk(tx_go, 1'b0, "R1 tx_go in reset");
        rst_n = 1'b1;

        // R2: software RTS only, CTS ignored
        cfg_rts = 1'b1;
        step();
        chk(rts_n, 1'b0, "R2 rts follows sw bit");
        chk(tx_go, 1'b1, "R2 tx_go with cts inactive");
        rx_count = CNT_W'(DEPTH);
        step();
        chk(rts_n, 1'b0, "R2 full fifo no effect");
        cfg_rts = 1'b0;
        step();
        chk(rts_n, 1'b1, "R2 sw bit cleared");
        rx_count = '0;

        // R11: interrupt masking
        cts_chg_req = 1'b1;
        #1;
        chk(cts_chg_irq, 1'b1, "R11 irq passes when afe=0");
        cfg_afe = 1'b1;
        #1;
        chk(cts_chg_irq, 1'b0, "R11 irq masked when afe=1");
        cts_chg_req = 1'b0;

        // R3 / R4: low trigger levels, fill then drain
        cfg_rts = 1'b1;
        for (int t = 0; t < 3; t++) begin
            int lvl;
            lvl = (t == 0) ? 1 : (t == 1) ? DEPTH / 4 : DEPTH / 2;
            trig_sel = 2'(t);
            rx_count = '0;
            step();
            chk(rts_n, 1'b0, "R3 empty fifo rts active");
            for (int c = 1; c <= lvl + 1; c++) begin
                rx_count = CNT_W'(c);
                step();
                chk(rts_n, (c >= lvl), "R3 fill vs trigger");
            end
            for (int c = lvl + 1; c >= 1; c--) begin
                rx_count = CNT_W'(c);
                rx_rd = 1'b1;
                step();
                chk(rts_n, (c != 1), "R4 held until emptied");
            end
            rx_rd = 1'b0;
            rx_count = '0;
            step();
            chk(rts_n, 1'b0, "R4 reopened when empty");
        end

        // R5 / R6: level 14
        trig_sel = 2'd3;
        for (int c = 0; c < DEPTH; c++) begin
            rx_count = CNT_W'(c);
            step();
            chk(rts_n, 1'b0, "R5 count alone below 16 keeps rts");
        end
        rx_first_bit = 1'b1;
        rx_count = CNT_W'(DEPTH - 2);
        step();
        chk(rts_n, 1'b0, "R5 first bit at count 14 ignored");
        rx_count = CNT_W'(DEPTH - 1);
        step();
        chk(rts_n, 1'b1, "R5 cutoff on 16th char first bit");
        rx_first_bit = 1'b0;
        step();
        chk(rts_n, 1'b1, "R5 still held during 16th char");
        rx_count = CNT_W'(DEPTH);
        step();
        chk(rts_n, 1'b1, "R6 held while full");
        rx_count = CNT_W'(DEPTH - 1);
        step();
        chk(rts_n, 1'b0, "R6 reopen at one free slot");
        rx_first_bit = 1'b1;
        step();
        rx_first_bit = 1'b0;
        chk(rts_n, 1'b1, "R5 second cutoff");
        rx_count = CNT_W'(DEPTH - 2);
        step();
        chk(rts_n, 1'b0, "R6 read during 16th char reopens");
        rx_count = CNT_W'(DEPTH);
        step();
        chk(rts_n, 1'b1, "R5 full without first bit");
        rx_count = '0;
        step();
        chk(rts_n, 1'b0, "R6 drained");

        // R7: CTS-only mode
        cfg_rts = 1'b0;
        rx_count = '0;
        step();
        chk(rts_n, 1'b1, "R7 rts inactive with sw bit clear");

        // R8 / R10: idle CTS gating (cts_n high since reset)
        cts_n = 1'b0;
        step();
        step();
        chk(tx_go, 1'b0, "R10 not yet resumed after two cycles");
        step();
        chk(tx_go, 1'b1, "R10 resumed after three cycles");
        cts_n = 1'b1;
        step();
        step();
        chk(tx_go, 1'b1, "R8 still go after two cycles");
        step();
        chk(tx_go, 1'b0, "R8 idle hold after three cycles");
        cts_n = 1'b0;
        repeat (3) step();
        chk(tx_go, 1'b1, "R7 cts gating works without auto rts");

        // R9: CTS inactive mid character, held at stop midpoint
        tx_busy = 1'b1;
        cts_n = 1'b1;
        repeat (4) step();
        chk(tx_go, 1'b1, "R9 mid character cts ignored");
        tx_last_stop = 1'b1;
        tx_tick16 = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            step();
            chk(tx_go, (k < 8), "R9 stop bit tick sampling");
        end
        tx_last_stop = 1'b0;
        tx_tick16 = 1'b0;
        tx_busy = 1'b0;
        cts_n = 1'b0;
        repeat (3) step();
        chk(tx_go, 1'b1, "R10 resume after hold");

        // R9: CTS drops after midpoint, next character allowed
        tx_busy = 1'b1;
        tx_last_stop = 1'b1;
        tx_tick16 = 1'b1;
        for (int k = 1; k <= 15; k++) begin
            if (k == 9) cts_n = 1'b1;
            step();
            chk(tx_go, 1'b1, "R9 late cts drop ignored");
        end
        tx_last_stop = 1'b0;
        tx_tick16 = 1'b0;
        step();
        chk(tx_go, 1'b1, "R9 next character started");
        tx_busy = 1'b0;
        step();
        chk(tx_go, 1'b0, "R8 hold once idle");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule